// File: doc/BRIEF.md
# Store-Set Dependence Predictor

At dispatch in an out-of-order core, this block decides which earlier in-flight store a load or store must wait for. It learns this from past memory-ordering violations. Every memory instruction may belong to one store set. A set-ID table, indexed by instruction address, holds that membership together with a small confidence counter. A second table holds, for each set, the tag of the youngest dispatched store of that set. At dispatch the block looks up the instruction's set and returns that store's tag as the dependence.

A violation report names a load PC and a store PC, and the block places both in one set. When both already had sets, only the two named entries are rewritten, so sets merge one entry at a time. A correct-speculation pulse lowers an entry's confidence. When a store completes, it releases its set's last-store slot, provided no younger store has taken that slot. Both tables are wiped at a fixed period so that dependences learned by accident fade away.

Top module: `ssp_predictor`

## Requirements
- R1: After reset, no dispatch returns a dependence (`dep_valid` is 0) until a violation has placed that instruction in a set.
- R2: The set-ID table has 2^IDX_W entries (4096 by default), indexed by `pc[IDX_W+1:2]`. Two PCs that differ only outside these bits share an entry; a PC differing in bit 2 does not.
- R3: A violation where neither PC has a valid set allocates a new set ID from a rolling counter for both. After a store of that set dispatches, a later load of the set returns that store's tag.
- R4: A violation where only one PC has a valid set copies that set ID to the other PC's entry.
- R5: A violation where both PCs have valid sets gives both entries the numerically smaller ID. Other members of the larger set keep their ID.
- R6: A dispatching store with a valid set gets a dependence on the set's previous last store, if there is one. The dispatching store then becomes the set's last store, so stores of a set form a chain.
- R7: A completing store (`cmp_valid`, `cmp_tag`) invalidates a last-store slot only if that slot still holds its tag.
- R8: Each set-ID entry carries a 2-bit counter. A violation sets it to 3, and each `good_valid` pulse for its PC lowers it by one, saturating at 0. An entry whose counter is 0 has no valid set.
- R9: Every CLEAR_PERIOD cycles (1,000,000 by default), all set-ID entries and last-store slots are invalidated.
- R10: When a dispatch and a violation update touch the same entry in one cycle, the dispatch sees the value from before the update. The update is visible from the next cycle.
- R11: `dep_valid` is 0 in any cycle without a dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A memory instruction dispatches this cycle |
| disp_pc | input | PC_W | PC of the dispatching instruction |
| disp_is_store | input | 1 | 1 for a store, 0 for a load |
| disp_tag | input | TAG_W | In-flight tag of the dispatching instruction |
| dep_valid | output | 1 | The dispatching instruction must wait for a store |
| dep_tag | output | TAG_W | Tag of the store to wait for |
| cmp_valid | input | 1 | A store has issued or completed |
| cmp_tag | input | TAG_W | Tag of that store |
| viol_valid | input | 1 | A memory-order violation is reported |
| viol_ld_pc | input | PC_W | PC of the offending load |
| viol_st_pc | input | PC_W | PC of the offending store |
| good_valid | input | 1 | A correct speculation is reported for a PC |
| good_pc | input | PC_W | PC whose confidence is lowered |

## Verification
The bench builds two sets and then merges them. A design that kept the larger ID, or that swept every member into the merged set, makes a later load wait for the wrong store. A completion with a stale tag follows a younger store of the same set; a design that clears the slot by set rather than by tag drops the younger store's dependence. The bench lowers a counter past zero, where a wrapping counter would bring back a dead dependence. It also sends a dispatch together with a violation on the same entry, where a design that forwards the update returns a dependence one cycle too early. A long idle stretch checks that the periodic wipe removes dependences the bench learned earlier.

// File: rtl/ssp_predictor.sv
module ssp_predictor #(
  parameter int PC_W         = 32,
  parameter int IDX_W        = 12,
  parameter int SET_W        = 7,
  parameter int TAG_W        = 8,
  parameter int CTR_W        = 2,
  parameter int CLEAR_PERIOD = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [PC_W-1:0]  disp_pc,
  input  logic             disp_is_store,
  input  logic [TAG_W-1:0] disp_tag,
  output logic             dep_valid,
  output logic [TAG_W-1:0] dep_tag,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_ld_pc,
  input  logic [PC_W-1:0]  viol_st_pc,
  input  logic             good_valid,
  input  logic [PC_W-1:0]  good_pc
);
  localparam int SIT_N = 1 << IDX_W;
  localparam int SETS  = 1 << SET_W;
  localparam int CLR_W = $clog2(CLEAR_PERIOD + 1);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [SET_W-1:0] sit_id  [SIT_N];
  logic [CTR_W-1:0] sit_ctr [SIT_N];
  logic             lf_v    [SETS];
  logic [TAG_W-1:0] lf_tag  [SETS];
  logic [SET_W-1:0] alloc_id;
  logic [CLR_W-1:0] clr_cnt;
  logic             clr;

  logic [IDX_W-1:0] d_idx, l_idx, s_idx, g_idx;
  logic             d_hit, l_hit, s_hit;
  logic [SET_W-1:0] d_id, l_id, s_id, m_id;
  logic             unused_pc_bits;

  assign d_idx = disp_pc[IDX_W+1:2];
  assign l_idx = viol_ld_pc[IDX_W+1:2];
  assign s_idx = viol_st_pc[IDX_W+1:2];
  assign g_idx = good_pc[IDX_W+1:2];
  assign unused_pc_bits = ^{disp_pc[PC_W-1:IDX_W+2], disp_pc[1:0],
                            viol_ld_pc[PC_W-1:IDX_W+2], viol_ld_pc[1:0],
                            viol_st_pc[PC_W-1:IDX_W+2], viol_st_pc[1:0],
                            good_pc[PC_W-1:IDX_W+2], good_pc[1:0]};

  assign d_hit = sit_ctr[d_idx] != '0;
  assign l_hit = sit_ctr[l_idx] != '0;
  assign s_hit = sit_ctr[s_idx] != '0;
  assign d_id  = sit_id[d_idx];
  assign l_id  = sit_id[l_idx];
  assign s_id  = sit_id[s_idx];

  assign dep_valid = disp_valid && d_hit && lf_v[d_id];
  assign dep_tag   = lf_tag[d_id];

  always_comb begin
    unique case ({l_hit, s_hit})
      2'b00:   m_id = alloc_id;
      2'b10:   m_id = l_id;
      2'b01:   m_id = s_id;
      default: m_id = (l_id < s_id) ? l_id : s_id;
    endcase
  end

  assign clr = clr_cnt == CLR_W'(CLEAR_PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   clr_cnt <= '0;
    else if (clr) clr_cnt <= '0;
    else          clr_cnt <= clr_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) alloc_id <= '0;
    else if (viol_valid && !clr && !l_hit && !s_hit) alloc_id <= alloc_id + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SIT_N; i++) sit_ctr[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < SIT_N; i++) sit_ctr[i] <= '0;
    end else begin
      if (good_valid && sit_ctr[g_idx] != '0) sit_ctr[g_idx] <= sit_ctr[g_idx] - 1'b1;
      if (viol_valid) begin
        sit_ctr[l_idx] <= CTR_MAX;
        sit_ctr[s_idx] <= CTR_MAX;
      end
    end

  always_ff @(posedge clk)
    if (viol_valid && !clr) begin
      sit_id[l_idx] <= m_id;
      sit_id[s_idx] <= m_id;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) lf_v[i] <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i < SETS; i++) lf_v[i] <= 1'b0;
    end else begin
      if (cmp_valid)
        for (int i = 0; i < SETS; i++)
          if (lf_v[i] && lf_tag[i] == cmp_tag) lf_v[i] <= 1'b0;
      if (disp_valid && disp_is_store && d_hit) lf_v[d_id] <= 1'b1;
    end

  always_ff @(posedge clk)
    if (disp_valid && disp_is_store && d_hit && !clr) lf_tag[d_id] <= disp_tag;
endmodule

// File: rtl/ssp_predictor_chk.sv
module ssp_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic [PC_W-1:0]  disp_pc,
  input logic             disp_is_store,
  input logic [TAG_W-1:0] disp_tag,
  input logic             dep_valid,
  input logic [TAG_W-1:0] dep_tag,
  input logic             cmp_valid,
  input logic [TAG_W-1:0] cmp_tag,
  input logic             viol_valid,
  input logic             good_valid,
  input logic             clr,
  input logic             d_hit
);
  p_idle_no_dep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |-> !dep_valid);

  p_store_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(disp_valid && disp_is_store && d_hit && !clr && !viol_valid && !good_valid && !cmp_valid)
     && disp_valid && disp_pc == $past(disp_pc))
    |-> (dep_valid && dep_tag == $past(disp_tag)));

  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && disp_valid) |-> !dep_valid);

  p_issue_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmp_valid && !(disp_valid && disp_is_store) && !clr) && disp_valid)
    |-> !(dep_valid && dep_tag == $past(cmp_tag)));
endmodule

bind ssp_predictor ssp_predictor_chk #(.PC_W(PC_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_pc(disp_pc),
  .disp_is_store(disp_is_store), .disp_tag(disp_tag), .dep_valid(dep_valid),
  .dep_tag(dep_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
  .viol_valid(viol_valid), .good_valid(good_valid), .clr(clr), .d_hit(d_hit)
);

// File: tb/test_ssp_predictor.sv
`timescale 1ns/1ps
module test_ssp_predictor;
  localparam int PC_W = 32;
  localparam int TAG_W = 8;
  localparam int PERIOD = 3000;

  logic clk = 0;
  logic rst_n = 0;
  logic disp_valid = 0, disp_is_store = 0;
  logic [PC_W-1:0] disp_pc = '0;
  logic [TAG_W-1:0] disp_tag = '0;
  logic dep_valid;
  logic [TAG_W-1:0] dep_tag;
  logic cmp_valid = 0;
  logic [TAG_W-1:0] cmp_tag = '0;
  logic viol_valid = 0;
  logic [PC_W-1:0] viol_ld_pc = '0, viol_st_pc = '0;
  logic good_valid = 0;
  logic [PC_W-1:0] good_pc = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  int    q_exp[$];
  string q_req[$];

  localparam logic [PC_W-1:0] LD1 = 32'h100, ST1 = 32'h200, LD2 = 32'h300,
                              ST2 = 32'h400, LD3 = 32'h500, ST3 = 32'h600;

  always #4 clk = ~clk;

  ssp_predictor #(.PC_W(PC_W), .TAG_W(TAG_W), .CLEAR_PERIOD(PERIOD)) i_ssp_predictor (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_pc(disp_pc),
    .disp_is_store(disp_is_store), .disp_tag(disp_tag), .dep_valid(dep_valid),
    .dep_tag(dep_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .good_valid(good_valid), .good_pc(good_pc));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (-1 = no dependence)", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic quiet();
    disp_valid = 0; cmp_valid = 0; viol_valid = 0; good_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); quiet(); end
  endtask

  task automatic disp(logic [PC_W-1:0] pc, bit st, int tag, int exp, string req);
    @(negedge clk); quiet();
    disp_valid = 1; disp_pc = pc; disp_is_store = st; disp_tag = TAG_W'(tag);
    q_exp.push_back(exp); q_req.push_back(req);
  endtask

  task automatic viol(logic [PC_W-1:0] lp, logic [PC_W-1:0] sp);
    @(negedge clk); quiet();
    viol_valid = 1; viol_ld_pc = lp; viol_st_pc = sp;
  endtask

  task automatic complete(int tag);
    @(negedge clk); quiet(); cmp_valid = 1; cmp_tag = TAG_W'(tag);
  endtask

  task automatic good(logic [PC_W-1:0] pc);
    @(negedge clk); quiet(); good_valid = 1; good_pc = pc;
  endtask

  initial forever begin
    @(negedge clk); #2;
    if (disp_valid) begin
      if (q_exp.size() == 0) chk(0, "R11 unexpected dispatch", 0, 0);
      else begin
        int e;
        int a;
        string r;
        e = q_exp.pop_front(); r = q_req.pop_front();
        a = dep_valid ? int'(dep_tag) : -1;
        chk(a == e, r, a, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    disp(LD1, 0, 1, -1, "R1 load after reset");
    disp(ST1, 1, 5, -1, "R1 store after reset");
    viol(LD1, ST1);
    disp(ST1, 1, 10, -1, "R3 first store of new set");
    disp(LD1, 0, 11, 10, "R3 load waits on set store");
    disp(ST1, 1, 12, 10, "R6 store chained behind store");
    disp(LD1, 0, 13, 12, "R6 load waits on youngest store");
    complete(10);
    disp(LD1, 0, 14, 12, "R7 stale tag keeps slot");
    complete(12);
    disp(LD1, 0, 15, -1, "R7 matching tag frees slot");
    viol(LD2, ST1);
    disp(ST1, 1, 20, -1, "R4 store refills slot");
    disp(LD2, 0, 21, 20, "R4 load inherits store set");
    viol(LD1, ST2);
    disp(ST2, 1, 22, 20, "R4 store inherits load set");
    disp(LD1, 0, 23, 22, "R4 load sees copied store");
    disp(LD1 + 32'h4000, 0, 24, 22, "R2 alias beyond bit 13");
    disp(LD1 + 32'h4, 0, 25, -1, "R2 bit 2 selects other entry");
    viol(LD3, ST3);
    disp(ST3, 1, 30, -1, "R3 second set store");
    disp(LD3, 0, 31, 30, "R3 second set load");
    viol(LD3, ST1);
    disp(ST1, 1, 31, 22, "R5 store keeps smaller set");
    disp(ST3, 1, 32, 30, "R5 unreported member keeps larger set");
    disp(LD3, 0, 33, 31, "R5 merged load takes smaller set");
    good(LD3); good(LD3);
    disp(LD3, 0, 34, 31, "R8 counter at 1 still valid");
    good(LD3);
    disp(LD3, 0, 35, -1, "R8 counter at 0 drops set");
    viol(LD3, ST1);
    disp(LD3, 0, 36, 31, "R8 violation restores counter");
    good(LD3); good(LD3); good(LD3); good(LD3);
    disp(LD3, 0, 37, -1, "R8 counter saturates at 0");
    @(negedge clk); quiet();
    disp_valid = 1; disp_pc = LD3; disp_is_store = 0; disp_tag = 8'd38;
    viol_valid = 1; viol_ld_pc = LD3; viol_st_pc = ST3;
    q_exp.push_back(-1); q_req.push_back("R10 dispatch sees old entry");
    disp(LD3, 0, 39, 32, "R10 update visible next cycle");
    idle(1);
    #2 chk(!dep_valid, "R11 no dependence while idle", int'(dep_valid), 0);
    idle(PERIOD);
    disp(LD3, 0, 40, -1, "R9 load set wiped");
    disp(ST1, 1, 41, -1, "R9 store set wiped");
    viol(LD1, ST1);
    disp(ST1, 1, 42, -1, "R9 relearn after wipe");
    disp(LD1, 0, 43, 42, "R9 relearned dependence");
    idle(3);
    report();
  end
endmodule